// File: doc/BRIEF.md
# DRAM Refresh-Address and Strobe Decode Logic

This block is the strobe decoder that sits on the device side of a dynamic RAM. It watches the row strobe, column strobe, write strobe and output-enable pins, all sampled on a fast internal clock. From their order it works out whether the current strobe cycle is a normal access, a refresh that uses only the row strobe, or a refresh where the column strobe leads. It then gives the cell array a row address, a column address, one-cycle read, write and refresh enables, and an enable for the data output driver.

A normal cycle takes its row from the address pins when the row strobe falls. It takes its column from the low address bits each time the column strobe falls, so page-mode accesses work. A column-first refresh does not use the pins for the row. The row comes from an internal 11-bit counter, and that counter advances when the cycle ends. If the column strobe goes high and then falls again while the row strobe is still low, the refresh turns into a full access to the counter row. This gives a fast way to test the refresh counter. A run of row-strobe-only refreshes puts the counter into a known state.

Top module: `dram_cbr_ctrl`

## Requirements
- R1: After reset, row_addr and col_addr are 0, and rd_en, wr_en, refresh and dq_oe are all 0.
- R2: In a normal cycle, row_addr takes the 11 address pins on the first clock after ras_n falls while cas_n is high. On the first clock after cas_n falls, col_addr takes addr[9:0]. If we_n is high at that point, rd_en pulses high for exactly one cycle.
- R3: If we_n is low at the column latch, wr_en pulses for one cycle and rd_en stays 0. rd_en and wr_en are never high together.
- R4: If cas_n is already low when ras_n falls, the cycle is a column-first refresh. row_addr takes the refresh counter value, there is no read or write enable, and refresh pulses for one cycle after ras_n rises.
- R5: The refresh counter increases by one when each column-first refresh ends, and it wraps from 2047 to 0.
- R6: A cycle in which ras_n falls and rises with no cas_n fall is a row-only refresh, and refresh pulses for one cycle after ras_n rises. When 8 of these cycles run back to back, the counter is set to 0, and every further back-to-back row-only refresh keeps it at 0. Any other kind of cycle restarts the run count.
- R7: During a column-first refresh, if cas_n rises and then falls again while ras_n is low, col_addr takes addr[9:0] and a read or write is enabled according to we_n. row_addr keeps the counter value.
- R8: During an active read, if we_n falls while cas_n stays low, wr_en pulses for one cycle (read-modify-write) and the output enable is withdrawn.
- R9: dq_oe is high only during a read access while both cas_n and oe_n are low. It is 0 for writes.
- R10: In a normal cycle, each new fall of cas_n latches a new column while row_addr stays unchanged (page mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | 11 | Multiplexed address pins |
| row_addr | output | 11 | Row address to the array |
| col_addr | output | 10 | Column address to the array |
| rd_en | output | 1 | One-cycle read enable |
| wr_en | output | 1 | One-cycle write enable |
| refresh | output | 1 | One-cycle refresh enable at the end of a refresh cycle |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The hardest condition to reach is the counter wrap from 2047 to 0, observed through a counter-test access. The pins can only reach it by way of the counter itself. The bench first clears the counter with eight row-only refreshes. It then runs more than 2048 column-first refreshes and checks the row each one reports against an arithmetic model. Some of those refreshes are turned into counter-test reads, writes and read-modify-writes, including the ones near the wrap.

// File: rtl/dram_cbr_ctrl.sv
module dram_cbr_ctrl #(
  parameter int          ROW_W       = 11,
  parameter int          COL_W       = 10,
  parameter int          INIT_CYCLES = 8,
  parameter logic [10:0] CNT_RESET   = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             rd_en,
  output logic             wr_en,
  output logic             refresh,
  output logic             dq_oe
);
  localparam int RW = $clog2(INIT_CYCLES + 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(INIT_CYCLES);
  localparam logic [RW-1:0] RUN_LAST = RW'(INIT_CYCLES - 1);

  typedef enum logic [1:0] {M_IDLE, M_NORM, M_CBR} mode_t;

  mode_t            mode;
  logic             ras_q, cas_q, we_q;
  logic             cas_seen, rd_act;
  logic [ROW_W-1:0] cnt;
  logic [RW-1:0]    run;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;

  assign dq_oe = rd_act & ~cas_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      mode     <= M_IDLE;
      cas_seen <= 1'b0;
      rd_act   <= 1'b0;
      cnt      <= CNT_RESET[ROW_W-1:0];
      run      <= '0;
      row_addr <= '0;
      col_addr <= '0;
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      refresh  <= 1'b0;
    end else begin
      ras_q   <= ras_n;
      cas_q   <= cas_n;
      we_q    <= we_n;
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      refresh <= 1'b0;
      if (ras_fall) begin
        cas_seen <= 1'b0;
        rd_act   <= 1'b0;
        if (!cas_n) begin
          mode     <= M_CBR;
          row_addr <= cnt;
        end else begin
          mode     <= M_NORM;
          row_addr <= addr;
        end
      end else if (ras_rise) begin
        mode   <= M_IDLE;
        rd_act <= 1'b0;
        if (mode == M_CBR) begin
          cnt     <= cnt + 1'b1;
          refresh <= 1'b1;
          run     <= '0;
        end else if (!cas_seen) begin
          refresh <= 1'b1;
          if (run >= RUN_LAST) begin
            cnt <= '0;
            run <= RUN_MAX;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end else if (mode != M_IDLE && !ras_n) begin
        if (cas_fall) begin
          cas_seen <= 1'b1;
          col_addr <= addr[COL_W-1:0];
          if (we_n) begin
            rd_en  <= 1'b1;
            rd_act <= 1'b1;
          end else begin
            wr_en  <= 1'b1;
            rd_act <= 1'b0;
          end
        end else if (cas_n) begin
          rd_act <= 1'b0;
        end else if (rd_act && we_q && !we_n) begin
          wr_en  <= 1'b1;
          rd_act <= 1'b0;
        end
      end
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R3
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (!rd_en && !wr_en)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && mode == M_CBR) |=> cnt == $past(cnt) + 1'b1); // R5
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_fall |=> $stable(col_addr)); // R2
  AST_CBR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CBR && (rd_en || wr_en)) |-> row_addr == cnt); // R7
  AST_OE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dq_oe); // R9
endmodule

// File: tb/dram_cbr_ctrl_tb.sv
`timescale 1ns/100ps
module dram_cbr_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [10:0] row_addr;
  logic [9:0]  col_addr;
  logic rd_en, wr_en, refresh, dq_oe;

  int checks = 0, errors = 0;
  logic [10:0] m_cnt = 11'h5A5;
  int m_run = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_cbr_ctrl #(.ROW_W(11), .COL_W(10), .INIT_CYCLES(8), .CNT_RESET(11'h5A5)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .row_addr(row_addr), .col_addr(col_addr), .rd_en(rd_en),
    .wr_en(wr_en), .refresh(refresh), .dq_oe(dq_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic norm_cycle(input logic [10:0] row, input logic [9:0] col,
                            input bit wr, input bit use_oe);
    @(negedge clk) ras_n = 1'b0; addr = row;
    @(negedge clk);
    chk(row_addr == row, "R2 row latch", row_addr, row);
    addr = {1'b0, col}; we_n = ~wr; cas_n = 1'b0; oe_n = ~use_oe;
    @(negedge clk);
    chk(col_addr == col, "R2 col latch", col_addr, col);
    chk(rd_en == !wr, "R2 read enable", rd_en, !wr);
    chk(wr_en == wr, "R3 write enable", wr_en, wr);
    chk(dq_oe == (!wr && use_oe), "R9 output enable", dq_oe, !wr && use_oe);
    @(negedge clk);
    chk(!rd_en && !wr_en, "R2 one-cycle pulse", rd_en | wr_en, 0);
    idle_all();
    @(negedge clk);
    chk(!refresh, "R6 no refresh after access", refresh, 0);
    chk(!dq_oe, "R9 output off", dq_oe, 0);
    m_run = 0;
  endtask

  task automatic ras_only(input logic [10:0] row);
    @(negedge clk) ras_n = 1'b0; addr = row;
    @(negedge clk);
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk);
    chk(refresh, "R6 row-only refresh pulse", refresh, 1);
    m_run = (m_run >= 8) ? 8 : m_run + 1;
    if (m_run == 8) m_cnt = '0;
  endtask

  task automatic cbr_cycle(input bit test, input bit wr, input logic [9:0] col,
                           input bit rmw, input string req);
    @(negedge clk) cas_n = 1'b0;
    @(negedge clk) ras_n = 1'b0;
    @(negedge clk);
    chk(row_addr == m_cnt, req, row_addr, m_cnt);
    chk(!rd_en && !wr_en, "R4 no access on refresh", rd_en | wr_en, 0);
    if (test) begin
      cas_n = 1'b1;
      @(negedge clk);
      addr = {1'b0, col}; we_n = ~wr; cas_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      chk(col_addr == col, "R7 test column", col_addr, col);
      chk(rd_en == !wr && wr_en == wr, "R7 test access", {rd_en, wr_en}, {!wr, wr});
      chk(row_addr == m_cnt, "R7 counter row", row_addr, m_cnt);
      chk(dq_oe == !wr, "R9 test output enable", dq_oe, !wr);
      if (rmw && !wr) begin
        we_n = 1'b0;
        @(negedge clk);
        chk(wr_en, "R8 read-modify-write enable", wr_en, 1);
        chk(!dq_oe, "R8 output withdrawn", dq_oe, 0);
      end
    end
    idle_all();
    @(negedge clk);
    chk(refresh, "R4 refresh at end", refresh, 1);
    m_cnt = m_cnt + 1'b1;
    m_run = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(row_addr == 0 && col_addr == 0, "R1 reset addresses", row_addr + col_addr, 0);
    chk(!rd_en && !wr_en && !refresh && !dq_oe, "R1 reset enables",
        {rd_en, wr_en, refresh, dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++)
      norm_cycle(11'((i * 131 + 7) & 11'h7FF), 10'((i * 37 + 3) & 10'h3FF), i[0], i[1]);

    cbr_cycle(1'b0, 1'b0, 10'd0, 1'b0, "R4 counter row");
    cbr_cycle(1'b0, 1'b0, 10'd0, 1'b0, "R5 counter step");

    for (int i = 0; i < 7; i++) ras_only(11'(i * 5));
    norm_cycle(11'h123, 10'h045, 1'b0, 1'b1);
    ras_only(11'h001);
    cbr_cycle(1'b0, 1'b0, 10'd0, 1'b0, "R6 run restarted");

    for (int i = 0; i < 9; i++) ras_only(11'(i + 40));
    cbr_cycle(1'b0, 1'b0, 10'd0, 1'b0, "R6 counter cleared");

    for (int i = 0; i < 2052; i++) begin
      bit t = (i % 128 == 3) || (i >= 2044);
      cbr_cycle(t, i[0], 10'((i * 13) & 10'h3FF), i[1], "R5 counter sweep");
    end
    chk(m_cnt == 11'd5, "R5 wrap model", m_cnt, 5);

    cbr_cycle(1'b1, 1'b0, 10'h2AA, 1'b1, "R8 rmw in test");

    @(negedge clk) ras_n = 1'b0; addr = 11'h5F0;
    @(negedge clk) addr = 11'h011; cas_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(rd_en, "R8 read before modify", rd_en, 1);
    chk(dq_oe, "R9 read drives", dq_oe, 1);
    oe_n = 1'b1;
    @(negedge clk);
    chk(!dq_oe, "R9 oe high blocks", dq_oe, 0);
    oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk(wr_en, "R8 late write", wr_en, 1);
    we_n = 1'b1; cas_n = 1'b1;
    @(negedge clk) addr = 11'h3C4; cas_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk(col_addr == 10'h3C4, "R10 page column", col_addr, 10'h3C4);
    chk(row_addr == 11'h5F0, "R10 page row held", row_addr, 11'h5F0);
    chk(wr_en && !rd_en, "R10 page write", {rd_en, wr_en}, 1);
    chk(!dq_oe, "R9 write no drive", dq_oe, 0);
    idle_all();
    @(negedge clk);
    chk(!refresh, "R6 access is not refresh", refresh, 0);
    m_run = 0;
    cbr_cycle(1'b0, 1'b0, 10'd0, 1'b0, "R5 counter after access");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule